// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer ratio and emits one single-cycle pulse per output period, intended for the feedback input of a phase comparator. It does not use one wide binary counter. A small prescaler divides by either 32 or 33, picked by a modulus-control line. A main count B and a swallow count A set that line: in each output period the first A prescaler cycles are 33 input clocks long and the remaining B−A are 32 long. The total ratio is therefore N = 32·B + A.

The user presents the swallow value A (5 bits) and the main value B (10 bits) as plain level inputs. The block samples them only at the end of an output period, or at any edge while the counters are held, so a period never mixes old and new settings. Two plain control inputs, a counter hold and a power-down, each freeze both counters at their zero state and silence the output. When both are released, counting restarts from zero, so the first pulse falls at a known place. There is no data stream at the boundary, so there is no valid/ready handshake and no back-pressure: every pin is a plain control or status level.

Top module: `pswallow_divider`

## Requirements
- R1: With legal settings, consecutive output pulses are exactly 32·B + A rising input-clock edges apart, where A = `swallow_val` and B = `main_val`.
- R2: The output `div_pulse` is high for exactly one input-clock cycle per output period and is never high on two consecutive cycles.
- R3: Values on `swallow_val` and `main_val` are sampled only on the edge that ends an output period, or on edges where the counters are held. A change in mid-period leaves the current period's length at the old ratio, and the next period uses the new one.
- R4: While `cnt_hold` is high, `div_pulse` stays low. After `cnt_hold` falls, the first pulse arrives exactly N edges after the first edge sampled with the hold low, where N is computed from the settings present during the hold.
- R5: `pwr_down` high has the same effect as `cnt_hold`: no pulses while it is asserted, and a restart from the zero state with the first pulse N edges after release.
- R6: `div_pulse` is low during asynchronous reset (`rst_n` low). The first edge after reset release captures the settings. The first pulse then arrives N+1 edges after reset release.
- R7: With A = 0 every prescaler cycle is 32 long, giving N = 32·B. With A = B every prescaler cycle is 33 long, giving N = 33·B.
- R8: The legal range is 3 ≤ B ≤ 1023, 0 ≤ A ≤ 31 and A ≤ B. Both range ends divide correctly: B=3, A=0 gives 96, and B=1023, A=31 gives 32767. Behaviour outside the legal range is unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_val | input | 5 | Swallow count A: number of 33-long prescaler cycles per period |
| main_val | input | 10 | Main count B: total prescaler cycles per period (3 to 1023) |
| cnt_hold | input | 1 | Holds both counters at zero while high |
| pwr_down | input | 1 | Power-down request; freezes counters at zero and silences the output |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |

## Verification
The bench goes after the ratio extremes (96 and 32767) and the two degenerate modulus patterns, A = 0 and A = B. A design that switched the modulus one prescaler cycle early or late would miss the expected count by exactly one. It changes A and B in the middle of a period. A design that loaded the values at once would produce one period of a mixed, wrong length. It asserts each hold input in mid-period and then releases it. A design that froze the counters instead of zeroing them, or that leaked a pulse during the hold, would give a first period that is short or unexpected. It also measures the gap from reset release, which catches a design that skipped the capture edge or counted during it.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int DEF_SWALLOW_W = 5;
  localparam int DEF_MAIN_W    = 10;
  localparam int DEF_PRESC_LOG = 5;

  function automatic int ratio_of(int main_cnt, int swallow_cnt, int presc_log);
    return main_cnt * (1 << presc_log) + swallow_cnt;
  endfunction
endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int PRESC_LOG = pswallow_pkg::DEF_PRESC_LOG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic mod_hi,
  output logic presc_tc
);
  localparam int CW = PRESC_LOG + 1;
  localparam logic [CW-1:0] LAST_LO = CW'((1 << PRESC_LOG) - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(1 << PRESC_LOG);

  logic [CW-1:0] cnt;

  assign presc_tc = !hold && (cnt == (mod_hi ? LAST_HI : LAST_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (hold)     cnt <= '0;
    else if (presc_tc) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R1: the prescaler phase never passes the longer modulus
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_HI);

  // R1: the modulus line may only move at a prescaler boundary or across a hold
  p_mod_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(presc_tc) && !$past(hold)) |-> $stable(mod_hi));
endmodule

// File: rtl/pswallow_counter.sv
module pswallow_counter #(
  parameter int SWALLOW_W = pswallow_pkg::DEF_SWALLOW_W,
  parameter int MAIN_W    = pswallow_pkg::DEF_MAIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold_req,
  input  logic [SWALLOW_W-1:0] swallow_in,
  input  logic [MAIN_W-1:0]    main_in,
  input  logic                 presc_tc,
  output logic                 mod_hi,
  output logic                 hold_eff,
  output logic                 pulse
);
  logic                 armed;
  logic [SWALLOW_W-1:0] swallow_set;
  logic [MAIN_W-1:0]    main_set;
  logic [MAIN_W-1:0]    main_idx;
  logic                 last_cycle;
  logic                 period_end;

  assign hold_eff   = hold_req || !armed;
  assign mod_hi     = main_idx < MAIN_W'(swallow_set);
  assign last_cycle = main_idx == (main_set - 1'b1);
  assign period_end = presc_tc && last_cycle && !hold_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      swallow_set <= '0;
      main_set    <= '0;
      main_idx    <= '0;
      pulse       <= 1'b0;
    end else begin
      armed <= 1'b1;
      pulse <= period_end;
      if (hold_eff || period_end) begin
        swallow_set <= swallow_in;
        main_set    <= main_in;
        main_idx    <= '0;
      end else if (presc_tc) begin
        main_idx <= main_idx + 1'b1;
      end
    end
  end

  // R3: active settings only change at a period end or during a hold
  p_settings_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(period_end) && !$past(hold_eff)) |-> ($stable(swallow_set) && $stable(main_set)));

  // R3: the cycle index stays inside the captured main count
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !hold_eff) |-> (main_idx < main_set));

  // R2: a pulse is never followed by another pulse
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int SWALLOW_W = pswallow_pkg::DEF_SWALLOW_W,
  parameter int MAIN_W    = pswallow_pkg::DEF_MAIN_W,
  parameter int PRESC_LOG = pswallow_pkg::DEF_PRESC_LOG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SWALLOW_W-1:0] swallow_val,
  input  logic [MAIN_W-1:0]    main_val,
  input  logic                 cnt_hold,
  input  logic                 pwr_down,
  output logic                 div_pulse
);
  logic mod_hi;
  logic hold_eff;
  logic presc_tc;

  pswallow_counter #(
    .SWALLOW_W(SWALLOW_W),
    .MAIN_W   (MAIN_W)
  ) i_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (cnt_hold || pwr_down),
    .swallow_in(swallow_val),
    .main_in   (main_val),
    .presc_tc  (presc_tc),
    .mod_hi    (mod_hi),
    .hold_eff  (hold_eff),
    .pulse     (div_pulse)
  );

  pswallow_prescaler #(
    .PRESC_LOG(PRESC_LOG)
  ) i_prescaler (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold_eff),
    .mod_hi  (mod_hi),
    .presc_tc(presc_tc)
  );

  // R4: counter hold silences the output on the following cycle
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hold |=> !div_pulse);

  // R5: power-down silences the output on the following cycle
  p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !div_pulse);
endmodule

// File: tb/test_pswallow_divider.sv
`timescale 1ns/1ps
module test_pswallow_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] swallow_val = 5'd5;
  logic [9:0] main_val = 10'd10;
  logic       cnt_hold = 1'b0;
  logic       pwr_down = 1'b0;
  logic       div_pulse;

  int n_checks = 0;
  int n_fail = 0;
  int wide_hits = 0;
  bit prev_pulse = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pswallow_divider i_pswallow_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .swallow_val(swallow_val),
    .main_val   (main_val),
    .cnt_hold   (cnt_hold),
    .pwr_down   (pwr_down),
    .div_pulse  (div_pulse)
  );

  function automatic int exp_ratio(int b, int a);
    return 32 * b + a;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts rising edges until the pulse is seen at a falling edge
  task automatic gap(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!div_pulse && n < 40000);
  endtask

  task automatic set_ab(int b, int a);
    main_val    = 10'(b);
    swallow_val = 5'(a);
  endtask

  task automatic measure(string req, int b, int a);
    int n;
    set_ab(b, a);
    gap(n);
    gap(n);
    chk(req, n, exp_ratio(b, a));
  endtask

  always @(negedge clk) begin
    if (rst_n && div_pulse && prev_pulse) wide_hits++;
    prev_pulse = div_pulse;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    int hits;
    void'($urandom(32'd9157));
    repeat (3) @(negedge clk);
    chk("R6 reset output low", int'(div_pulse), 0);
    rst_n = 1'b1;
    gap(n);
    chk("R6 first pulse after reset", n, exp_ratio(10, 5) + 1);
    gap(n);
    chk("R1 steady ratio 10/5", n, exp_ratio(10, 5));

    // range ends and degenerate modulus patterns
    measure("R8 minimum ratio", 3, 0);
    measure("R7 A equals B", 3, 3);
    measure("R7 A zero", 20, 0);
    measure("R7 A equals B 31", 31, 31);

    // random legal settings
    for (int i = 0; i < 25; i++) begin
      int b;
      int a;
      b = 3 + int'($urandom_range(0, 37));
      a = int'($urandom_range(0, (b < 31) ? b : 31));
      measure("R1 random ratio", b, a);
    end

    // R3: change settings in mid-period
    set_ab(12, 7);
    gap(n);
    gap(n);
    n = 0;
    repeat (40) begin
      @(posedge clk);
      n++;
    end
    @(negedge clk);
    set_ab(25, 2);
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!div_pulse && n < 40000);
    chk("R3 period keeps old ratio", n, exp_ratio(12, 7));
    gap(n);
    chk("R3 next period uses new ratio", n, exp_ratio(25, 2));

    // R4: counter hold in mid-period
    repeat (57) @(negedge clk);
    cnt_hold = 1'b1;
    set_ab(4, 3);
    hits = 0;
    repeat (500) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    chk("R4 no pulse during hold", hits, 0);
    cnt_hold = 1'b0;
    gap(n);
    chk("R4 restart after hold", n, exp_ratio(4, 3));

    // R5: power-down in mid-period
    repeat (33) @(negedge clk);
    pwr_down = 1'b1;
    set_ab(9, 9);
    hits = 0;
    repeat (500) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    chk("R5 no pulse during power-down", hits, 0);
    pwr_down = 1'b0;
    gap(n);
    chk("R5 restart after power-down", n, exp_ratio(9, 9));
    gap(n);
    chk("R5 steady after power-down", n, exp_ratio(9, 9));

    // R8: largest ratio
    measure("R8 maximum ratio", 1023, 31);

    @(negedge clk);
    chk("R2 pulse one cycle wide", int'(div_pulse), 0);
    chk("R2 no back-to-back pulses", wide_hits, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule